// File: doc/BRIEF.md
# Serial Configuration Register Target (block-transfer only)

This block is a two-wire serial bus target that keeps eight bytes of clock-control configuration and identification. The bus lines are oversampled by a fast system clock through two-flop synchronisers. The data line is only ever pulled low, so the pad must be open-drain. The bus runs in standard mode at 100 kbit/s or less. The block does not stretch the clock, does not support random access through a repeated start, and does not support 10-bit addressing.

A controller writes with address byte D4h. It then sends a command byte and a count byte, which are acknowledged and thrown away. The data bytes that follow fill the bank from byte 0 upward. A stop may come after any whole byte, and whatever was written up to that point stays. A controller reads with address byte D5h. The block first returns a byte count, then bytes 0 to 7 in order. The register contents leave the block on a flat vector for the clock-control logic. Two board strap pins are captured once after reset and appear in byte 1.

Top module: `i2c_cfg_target`

## Requirements
- R1: Address byte D4h (write) and D5h (read) are acknowledged by holding SDA low during the ninth clock. Any other address byte gets no acknowledge, and the block keeps SDA released until the next start.
- R2: On a write, the first two bytes after the address are acknowledged and none of their bits reach any register.
- R3: Write data bytes land in byte 0, 1, 2 … in arrival order. After a stop, every byte already completed keeps its new value and the bytes not reached keep their old value.
- R4: A read returns 07h first, then bytes 0 to 7 in ascending order, each sent MSB first. A byte requested after byte 7 reads FFh.
- R5: After reset, byte 0 is 86h, bytes 2 to 6 are FFh, byte 7 is 01h, and byte 1 is FFh except for bits 5:4 (see R7). Byte i appears on `cfg_bytes[8i+7:8i]`.
- R6: Byte 6, byte 7, and bits 5:4 and 1:0 of byte 1 are not changed by writes. Only bits 7:6 and 3:2 of byte 1 take written data.
- R7: Byte 1 bit 5 shows `strap_b` and bit 4 shows `strap_a`, both as sampled on the first clock after reset is released. Later strap changes have no effect.
- R8: A data byte sent after the eighth data byte is still acknowledged, changes no register and does not wrap around to byte 0.
- R9: When the controller does not acknowledge a read byte, the block releases SDA and stays silent through any further SCL pulses until a stop. After that stop it serves the next transfer normally.
- R10: The block changes SDA only in the cycle after it detects a falling SCL edge, a start or a stop, so SDA stays steady while SCL is high. Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high.
- R11: Every write data byte that follows an accepted write address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset that loads the register defaults |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| strap_a | input | 1 | Board strap captured into byte 1 bit 4 |
| strap_b | input | 1 | Board strap captured into byte 1 bit 5 |
| sda_pull_low | output | 1 | When high, the open-drain pad pulls SDA low |
| cfg_bytes | output | 64 | Register bank, byte i on bits 8i+7:8i |

## Verification
The assertions check on every cycle that SDA only moves right after an SCL fall, a start or a stop. They also check that the line stays released while the block waits for a stop, that a strobe into byte 0 shows up on the output on the next cycle, and that the captured straps never change after capture. Only the bench scenarios can show the byte-level protocol: which addresses get an acknowledge, that header bytes are dropped, that the read stream starts with the count and then follows register order, that excess writes do not wrap, and that traffic resumes after a refused read.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  localparam int N_REG  = 8;
  localparam int REG_W  = 8;
  localparam int SLOT_W = $clog2(N_REG);
  localparam int IX_W   = 4;
  localparam int HDR_BYTES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RDACK,
    ST_HOLD
  } phase_t;

  // address byte carries the 7-bit target address above the direction bit
  function automatic logic f_addr_hit(input logic [7:0] b, input logic [6:0] a7);
    return b[7:1] == a7;
  endfunction

  // write stream position -> register slot (headers occupy positions 0 and 1)
  function automatic logic [IX_W-1:0] f_data_slot(input logic [IX_W-1:0] ix);
    return ix - IX_W'(HDR_BYTES);
  endfunction

  function automatic logic f_slot_valid(input logic [IX_W-1:0] ix);
    return (ix >= IX_W'(HDR_BYTES)) && (ix < IX_W'(HDR_BYTES + N_REG));
  endfunction

  // read stream position 0 is the count, positions 1..N_REG the bank
  function automatic logic [REG_W-1:0] f_read_pick(input logic [IX_W-1:0] ix,
                                                   input logic [N_REG*REG_W-1:0] bank,
                                                   input logic [REG_W-1:0] cnt);
    int s;
    if (ix == '0) return cnt;
    if (ix > IX_W'(N_REG)) return '1;
    s = int'(ix) - 1;
    return bank[s*REG_W +: REG_W];
  endfunction

  function automatic logic [REG_W-1:0] f_write_mask(input int slot);
    case (slot)
      0, 2, 3, 4, 5: return 8'hFF;
      1:             return 8'hCC;
      default:       return 8'h00;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] f_reset_val(input int slot, input logic [7:0] b0,
                                                   input logic [7:0] rev, input logic [7:0] dev);
    case (slot)
      0:       return b0;
      6:       return rev;
      7:       return dev;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h6A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [REG_W-1:0]  rd_byte,
  output logic [IX_W-1:0]   rd_ix,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [REG_W-1:0]  wr_data,
  output logic              sda_oe
);
  phase_t          state;
  logic [2:0]      bitcnt;
  logic [7:0]      shreg, txreg;
  logic            got8, is_read, nacked;
  logic [IX_W-1:0] wr_ix;
  logic [IX_W-1:0] slot_full;

  assign slot_full = f_data_slot(wr_ix);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txreg   <= '0;
      got8    <= 1'b0;
      is_read <= 1'b0;
      nacked  <= 1'b0;
      wr_ix   <= '0;
      rd_ix   <= '0;
      wr_en   <= 1'b0;
      wr_slot <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        got8   <= 1'b0;
        sda_oe <= 1'b0;
        wr_ix  <= '0;
        rd_ix  <= '0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) got8 <= 1'b1;
            end else if (scl_fall && got8) begin
              got8 <= 1'b0;
              if (state == ST_ADDR) begin
                if (f_addr_hit(shreg, TARGET_ADDR)) begin
                  is_read <= shreg[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (f_slot_valid(wr_ix)) begin
                  wr_en   <= 1'b1;
                  wr_slot <= slot_full[SLOT_W-1:0];
                  wr_data <= shreg;
                end
                if (wr_ix != '1) wr_ix <= wr_ix + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                txreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                if (rd_ix != '1) rd_ix <= rd_ix + 1'b1;
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_RDACK;
              end else begin
                bitcnt <= bitcnt + 3'd1;
                txreg  <= {txreg[6:0], 1'b0};
                sda_oe <= ~txreg[6];
              end
            end
          end
          ST_RDACK: begin
            if (scl_rise) begin
              nacked <= sda_s;
            end else if (scl_fall) begin
              if (nacked) begin
                state <= ST_HOLD;
              end else begin
                txreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                bitcnt <= '0;
                if (rd_ix != '1) rd_ix <= rd_ix + 1'b1;
                state  <= ST_RD;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R10: the data line only moves right after SCL goes low or a start/stop
  a_r10_sda_moves_after_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R9: after a refused read (or a foreign address) the line stays released
  a_r9_released_while_holding: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !sda_oe);
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import i2c_cfg_pkg::*;
#(
  parameter logic [7:0] DEF_B0  = 8'h86,
  parameter logic [7:0] REV_VEN = 8'hFF,
  parameter logic [7:0] DEV_ID  = 8'h01
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_a,
  input  logic                   strap_b,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic [REG_W-1:0]       wr_data,
  output logic [N_REG*REG_W-1:0] bank_flat
);
  logic [REG_W-1:0] store_q [N_REG];
  logic [1:0]       strap_lat;
  logic             strap_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REG; i++) store_q[i] <= f_reset_val(i, DEF_B0, REV_VEN, DEV_ID);
    end else if (wr_en) begin
      for (int i = 0; i < N_REG; i++) begin
        if (wr_slot == SLOT_W'(i))
          store_q[i] <= (store_q[i] & ~f_write_mask(i)) | (wr_data & f_write_mask(i));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_lat   <= '0;
      strap_taken <= 1'b0;
    end else if (!strap_taken) begin
      strap_lat   <= {strap_b, strap_a};
      strap_taken <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_view
    if (g == 1) begin : g_strap
      assign bank_flat[g*REG_W +: REG_W] = {store_q[g][7:6], strap_lat, store_q[g][3:0]};
    end else begin : g_plain
      assign bank_flat[g*REG_W +: REG_W] = store_q[g];
    end
  end

  // R3: a strobe into byte 0 is visible on the output one cycle later
  a_r3_slot0_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == '0) |=> (bank_flat[REG_W-1:0] == $past(wr_data)));

  // R7: captured straps never move once taken
  a_r7_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strap_taken |=> $stable(strap_lat));
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h6A,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEF_B0      = 8'h86,
  parameter logic [7:0] REV_VEN     = 8'hFF,
  parameter logic [7:0] DEV_ID      = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        strap_a,
  input  logic        strap_b,
  output logic        sda_pull_low,
  output logic [63:0] cfg_bytes
);
  localparam logic [REG_W-1:0] COUNT_BYTE = REG_W'(N_REG - 1);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IX_W-1:0]   rd_ix;
  logic [REG_W-1:0]  rd_byte;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [REG_W-1:0]  wr_data;
  logic [N_REG*REG_W-1:0] bank_flat;

  i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rd_byte = f_read_pick(rd_ix, bank_flat, COUNT_BYTE);

  i2c_cfg_engine #(.TARGET_ADDR(TARGET_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .rd_ix(rd_ix), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .sda_oe(sda_pull_low)
  );

  i2c_cfg_bank #(.DEF_B0(DEF_B0), .REV_VEN(REV_VEN), .DEV_ID(DEV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data), .bank_flat(bank_flat)
  );

  assign cfg_bytes = bank_flat;
endmodule

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_a = 1'b0, strap_b = 1'b1;
  logic sda_pull_low;
  logic [63:0] cfg_bytes;
  wire  sda_line = sda_m & ~sda_pull_low;

  int checks = 0, fails = 0, hold_err = 0;
  logic [7:0] exp_b [8];
  logic [7:0] rdbuf [10];

  always #4 clk = ~clk;

  i2c_cfg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap_a(strap_a), .strap_b(strap_b), .sda_pull_low(sda_pull_low),
    .cfg_bytes(cfg_bytes)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wq;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    wq(); sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      wq(); sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0;
    end
    wq(); sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    a1 = sda_line; wq();
    a2 = sda_line;
    scl_m = 1'b0;
    if (a1 != a2) hold_err++;
    ack = !a1;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); wq();
      scl_m = 1'b1; wq();
      b = {b[6:0], sda_line}; wq();
      scl_m = 1'b0;
    end
    wq(); sda_m = !give_ack; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic read_n(input int n);
    logic ack;
    bus_start();
    send_byte(8'hD5, ack);
    chk(ack, "R1 read address acknowledged", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rdbuf[i]);
    bus_stop();
  endtask

  task automatic check_port_bytes(input string req);
    for (int i = 0; i < 8; i++)
      chk(cfg_bytes[8*i +: 8] == exp_b[i], req, cfg_bytes[8*i +: 8], exp_b[i]);
  endtask

  function automatic logic [7:0] merge(input int slot, input logic [7:0] old, input logic [7:0] v);
    logic [7:0] m;
    m = (slot == 1) ? 8'hCC : (slot <= 5 ? 8'hFF : 8'h00);
    return (old & ~m) | (v & m);
  endfunction

  task automatic t_defaults;
    exp_b[0] = 8'h86;
    exp_b[1] = {2'b11, strap_b, strap_a, 4'hF};
    for (int i = 2; i < 7; i++) exp_b[i] = 8'hFF;
    exp_b[7] = 8'h01;
    check_port_bytes("R5 reset value");
    chk(sda_pull_low == 1'b0, "R5 line released after reset", sda_pull_low, 0);
  endtask

  task automatic t_read_all;
    read_n(10);
    chk(rdbuf[0] == 8'h07, "R4 byte count first", rdbuf[0], 8'h07);
    for (int i = 0; i < 8; i++)
      chk(rdbuf[i+1] == exp_b[i], "R4 read order", rdbuf[i+1], exp_b[i]);
    chk(rdbuf[9] == 8'hFF, "R4 past end reads FF", rdbuf[9], 8'hFF);
    chk(hold_err == 0, "R10 SDA steady while SCL high", hold_err, 0);
  endtask

  task automatic t_bad_addr;
    logic ack;
    bus_start();
    send_byte(8'hA0, ack);
    chk(!ack, "R1 foreign address not acknowledged", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R1 silent after foreign address", ack, 0);
    bus_stop();
    check_port_bytes("R1 foreign traffic changes nothing");
  endtask

  task automatic t_write_partial;
    logic ack;
    bus_start();
    send_byte(8'hD4, ack);
    chk(ack, "R1 write address acknowledged", ack, 1);
    send_byte(8'h55, ack);
    chk(ack, "R2 command byte acknowledged", ack, 1);
    send_byte(8'h33, ack);
    chk(ack, "R2 count byte acknowledged", ack, 1);
    send_byte(8'h12, ack);
    chk(ack, "R11 data byte acknowledged", ack, 1);
    send_byte(8'h34, ack);
    chk(ack, "R11 data byte acknowledged", ack, 1);
    bus_stop();
    exp_b[0] = 8'h12;
    exp_b[1] = merge(1, exp_b[1], 8'h34);
    chk(cfg_bytes[7:0] == 8'h12, "R2 header not stored in byte 0", cfg_bytes[7:0], 8'h12);
    chk(cfg_bytes[15:8] == {2'b00, strap_b, strap_a, 4'h7}, "R6 byte 1 write mask",
        cfg_bytes[15:8], {2'b00, strap_b, strap_a, 4'h7});
    check_port_bytes("R3 partial write kept");
  endtask

  task automatic t_write_over;
    logic ack;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD4, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    for (int k = 0; k < 11; k++) begin
      v = 8'hC3 ^ 8'(k * 37);
      send_byte(v, ack);
      if (k >= 8) chk(ack, "R8 excess byte acknowledged", ack, 1);
      else chk(ack, "R11 data byte acknowledged", ack, 1);
      if (k < 8) exp_b[k] = merge(k, exp_b[k], v);
    end
    bus_stop();
    chk(cfg_bytes[7:0] == 8'hC3, "R8 no wrap into byte 0", cfg_bytes[7:0], 8'hC3);
    chk(cfg_bytes[63:48] == 16'h01FF, "R6 id bytes unchanged", cfg_bytes[63:48], 16'h01FF);
    check_port_bytes("R3 full write");
  endtask

  task automatic t_straps;
    strap_a = 1'b1; strap_b = 1'b0;
    wq();
    chk(cfg_bytes[13:12] == 2'b10, "R7 strap capture frozen", cfg_bytes[13:12], 2'b10);
    read_n(3);
    chk(rdbuf[2] == exp_b[1], "R7 byte 1 readback", rdbuf[2], exp_b[1]);
  endtask

  task automatic t_nack;
    logic [7:0] b;
    int driven;
    bus_start();
    begin : addr_phase
      logic ack;
      send_byte(8'hD5, ack);
    end
    recv_byte(1'b0, b);
    chk(b == 8'h07, "R4 count before refusal", b, 8'h07);
    driven = 0;
    for (int i = 0; i < 18; i++) begin
      wq(); scl_m = 1'b1; if (sda_pull_low) driven++;
      wq(); if (sda_pull_low) driven++; scl_m = 1'b0;
      wq(); if (sda_pull_low) driven++;
    end
    chk(driven == 0, "R9 released after refused byte", driven, 0);
    bus_stop();
    read_n(2);
    chk(rdbuf[1] == exp_b[0], "R9 next read after stop", rdbuf[1], exp_b[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    t_defaults();
    t_read_all();
    t_bad_addr();
    t_write_partial();
    t_write_over();
    t_straps();
    t_nack();
    t_read_all();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule